// File: doc/BRIEF.md
# Bus Access Ordering Guard

The guard sits between the memory-request stage of a pipelined CPU and a shared data bus. The CPU has two request channels. The write channel carries the access of the older instruction. The read channel carries the access of the younger one. Whatever the write channel presents is treated as older than the read presented beside it. The guard merges the two channels into a single registered bus request stream.

Left alone, the pipeline lets a younger read reach the bus ahead of an older write that is still waiting, and the guard keeps that reordering wherever it is harmless. When the read, or any older write it could pass, falls inside a protected zone whose enable bit is set, the guard holds the read with `rd_stall` until every such write has been accepted by the bus. A read to the same address as an older write is always held, protected or not. Holding a read costs stall cycles. That cost is the price of seeing the accesses on the bus in program order.

Each zone is given by a base address and a size on configuration inputs. A register holds one enable bit per zone. Every bit is set out of reset, so every zone is protected until software clears it. Two neighbouring peripheral windows can share one zone by giving that zone a base and size that cover both.

Top module: `bus_order_guard`

## Requirements
- R1: Out of reset, `bus_valid` is 0 and `wr_ready` is 1, and every zone enable bit is 1. A write and a read that are both inside a zone therefore come out on the bus write first, with no configuration needed.
- R2: Take an older write and a younger read to different addresses, with neither address in an enabled zone. The read is issued to the bus first, the write follows, and `rd_stall` stays 0.
- R3: If the read address or the address of any older write is in an enabled zone, the read is held. It reaches the bus only after all of those writes have been accepted by the bus.
- R4: `rd_stall` is 1 only while `rd_valid` is 1 and the read cannot be taken. A taken read is presented on the bus in the next cycle, with `bus_we`=0 and the same address. With the bus always ready, a protected write and read presented in the same cycle cost exactly 2 stall cycles, and the read appears in the cycle after the write is accepted.
- R5: A read whose address equals that of an older write is always placed after that write, even with all zone enables 0.
- R6: When `cfg_en_we`=1 at a clock edge, the enable register loads `cfg_en_val`, where bit z enables zone z. A zone whose bit is 0 imposes no ordering.
- R7: Zone z covers addresses a with base_z ≤ a < base_z + size_z. Base and size are field z of `zone_base` and `zone_size`, bits [z*AW +: AW]. A size of 0 covers no address.
- R8: While `bus_valid`=1 and `bus_ready`=0, `bus_valid`, `bus_we`, `bus_addr` and `bus_wdata` hold their values. A request counts as accepted in a cycle where both are 1.
- R9: Writes reach the bus in arrival order, each exactly once. One pending write can be held. While it cannot leave, `wr_ready` is 0, and a write is taken only in a cycle where `wr_valid` and `wr_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write request present (older access) |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_ready | output | 1 | Write taken this cycle when `wr_valid` is 1 |
| rd_valid | input | 1 | Read request present (younger access) |
| rd_addr | input | AW | Read address |
| rd_stall | output | 1 | Read held this cycle; the CPU keeps it presented |
| cfg_en_we | input | 1 | Load strobe for the zone enable register |
| cfg_en_val | input | NZ | New zone enable bits |
| zone_base | input | NZ*AW | Base address of each zone |
| zone_size | input | NZ*AW | Size of each zone in address units |
| bus_valid | output | 1 | Bus request valid |
| bus_we | output | 1 | 1 for a write request, 0 for a read |
| bus_addr | output | AW | Bus request address |
| bus_wdata | output | DW | Write data; 0 on reads |
| bus_ready | input | 1 | Bus accepts the current request |

## Verification
The bench probes the zone edges one address at a time: base−1, base, base+size−1 and base+size, plus a zone of size zero. A range test that is off by one would reorder a pair at an edge, or fail to reorder one. It pairs same-address accesses with every zone disabled, where a guard that only looks at zones would let the read go first and return stale data. It also checks the exact stall count of a protected pair. A guard that released the read one cycle early would break the order, and one that released it late would waste cycles. Random traffic against a bus whose ready signal toggles shows whether held requests stay stable and whether writes are ever lost, duplicated or reordered among themselves.

// File: rtl/bog_pkg.sv
// Shared types for the bus ordering guard.
// Assumes nothing beyond single-bit request kinds.
package bog_pkg;
    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } bog_op_e;
endpackage

// File: rtl/bog_zone_hit.sv
// Zone membership test for one address against NZ programmable zones.
// A zone covers base <= addr < base+size; size 0 covers nothing.
// Assumes base+size does not wrap past the top of the address space.
module bog_zone_hit #(
    parameter int AW = 16,
    parameter int NZ = 2
) (
    input  logic [AW-1:0]    addr,
    input  logic [NZ*AW-1:0] zone_base,
    input  logic [NZ*AW-1:0] zone_size,
    input  logic [NZ-1:0]    zone_en,
    output logic             hit
);
    logic [NZ-1:0] in_zone;

    for (genvar z = 0; z < NZ; z++) begin : g_zone
        logic [AW-1:0] base_z;
        logic [AW-1:0] size_z;
        logic [AW-1:0] offset_z;
        assign base_z   = zone_base[z*AW +: AW];
        assign size_z   = zone_size[z*AW +: AW];
        assign offset_z = addr - base_z;
        // Purpose: flag the address as inside enabled zone z.
        always_comb begin
            in_zone[z] = zone_en[z] && (addr >= base_z) && (offset_z < size_z);
        end
    end

    assign hit = |in_zone;
endmodule

// File: rtl/bog_wr_slot.sv
// Single-entry holding register for the oldest write not yet on the bus.
// Assumes the caller never asserts load and drop with conflicting intent:
// a load in the same cycle as a drop replaces the leaving entry.
module bog_wr_slot #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          drop,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    // Purpose: capture a new write or retire the one issued to the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            addr  <= load_addr;
            data  <= load_data;
        end else if (drop) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/bog_bus_stage.sv
// Registered bus request stage; holds its request until the bus is ready.
// Assumes put is only raised when free is 1.
module bog_bus_stage #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_ready,
    input  logic             put,
    input  bog_pkg::bog_op_e put_op,
    input  logic [AW-1:0]    put_addr,
    input  logic [DW-1:0]    put_data,
    output logic             free,
    output logic             valid,
    output logic             we,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    wdata
);
    // Purpose: the stage can take a request when empty or when emptying now.
    always_comb begin
        free = !valid || bus_ready;
    end

    // Purpose: load a new request, or clear the stage once accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            we    <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else if (put) begin
            valid <= 1'b1;
            we    <= (put_op == bog_pkg::OP_WR);
            addr  <= put_addr;
            wdata <= put_data;
        end else if (bus_ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_order_guard.sv
// Bus access ordering guard (top).
// Merges an older write channel and a younger read channel onto one bus.
// A read may pass older writes unless it or one of them lies in an enabled
// protected zone, or the addresses match; then the read is stalled until the
// writes are accepted. Zone enables reset to all ones.
// Assumes the CPU holds a stalled read and an unaccepted write unchanged.
module bus_order_guard #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int NZ = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_ready,
    input  logic             rd_valid,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_stall,
    input  logic             cfg_en_we,
    input  logic [NZ-1:0]    cfg_en_val,
    input  logic [NZ*AW-1:0] zone_base,
    input  logic [NZ*AW-1:0] zone_size,
    output logic             bus_valid,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic             bus_ready
);
    import bog_pkg::*;

    logic [NZ-1:0]    zone_en_q;
    logic             slot_valid;
    logic [AW-1:0]    slot_addr;
    logic [DW-1:0]    slot_data;
    logic             hit_slot, hit_new, hit_rd;
    logic             block_slot, block_new;
    logic             stage_free;
    logic             rd_take, slot_issue, slot_load;
    logic             put;
    bog_op_e          put_op;
    logic [AW-1:0]    put_addr;
    logic [DW-1:0]    put_data;

    // Purpose: per-zone enable register, all zones protected out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone_en_q <= '1;
        end else if (cfg_en_we) begin
            zone_en_q <= cfg_en_val;
        end
    end

    bog_zone_hit #(.AW(AW), .NZ(NZ)) i_hit_slot (
        .addr(slot_addr), .zone_base(zone_base), .zone_size(zone_size),
        .zone_en(zone_en_q), .hit(hit_slot)
    );
    bog_zone_hit #(.AW(AW), .NZ(NZ)) i_hit_new (
        .addr(wr_addr), .zone_base(zone_base), .zone_size(zone_size),
        .zone_en(zone_en_q), .hit(hit_new)
    );
    bog_zone_hit #(.AW(AW), .NZ(NZ)) i_hit_rd (
        .addr(rd_addr), .zone_base(zone_base), .zone_size(zone_size),
        .zone_en(zone_en_q), .hit(hit_rd)
    );

    // Purpose: decide whether the read must wait for each older write.
    always_comb begin
        block_slot = slot_valid && (hit_slot || hit_rd || (slot_addr == rd_addr));
        block_new  = wr_valid   && (hit_new  || hit_rd || (wr_addr   == rd_addr));
    end

    // Purpose: pick what enters the bus stage and which channels advance.
    always_comb begin
        rd_take    = stage_free && rd_valid && !block_slot && !block_new;
        slot_issue = stage_free && slot_valid && !rd_take;
        wr_ready   = !slot_valid || slot_issue;
        slot_load  = wr_valid && wr_ready;
        rd_stall   = rd_valid && !rd_take;
    end

    // Purpose: form the request handed to the bus stage.
    always_comb begin
        put      = rd_take || slot_issue;
        put_op   = rd_take ? OP_RD : OP_WR;
        put_addr = rd_take ? rd_addr : slot_addr;
        put_data = rd_take ? '0 : slot_data;
    end

    bog_wr_slot #(.AW(AW), .DW(DW)) i_slot (
        .clk(clk), .rst_n(rst_n),
        .load(slot_load), .load_addr(wr_addr), .load_data(wr_data),
        .drop(slot_issue),
        .valid(slot_valid), .addr(slot_addr), .data(slot_data)
    );

    bog_bus_stage #(.AW(AW), .DW(DW)) i_stage (
        .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready),
        .put(put), .put_op(put_op), .put_addr(put_addr), .put_data(put_data),
        .free(stage_free),
        .valid(bus_valid), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata)
    );
endmodule

// File: rtl/bog_chk.sv
// Assertion checker for bus_order_guard, attached by bind below.
// Assumes it observes the top's ports and its pending-write slot.
module bog_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_ready,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          rd_valid,
    input logic [AW-1:0] rd_addr,
    input logic          rd_stall,
    input logic          wr_ready,
    input logic          slot_valid,
    input logic [AW-1:0] slot_addr
);
    // R1: the bus is idle after a reset cycle.
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !bus_valid);

    // R8: a request not yet accepted stays put.
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_we) &&
        $stable(bus_addr) && $stable(bus_wdata));

    // R4: stall only accompanies a presented read.
    a_r4_stall_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |-> rd_valid);

    // R4: a taken read is on the bus next cycle with its address.
    a_r4_read_issued: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_stall |=> bus_valid && !bus_we && bus_addr == $past(rd_addr));

    // R5: a read never passes a pending write to the same address.
    a_r5_same_addr_order: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_stall && slot_valid |-> rd_addr != slot_addr);

    // R9: the write channel is only blocked by a busy bus or a passing read.
    a_r9_block_reason: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> (bus_valid && !bus_ready) || (rd_valid && !rd_stall));
endmodule

bind bus_order_guard bog_chk #(.AW(AW), .DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_stall(rd_stall),
    .wr_ready(wr_ready), .slot_valid(slot_valid), .slot_addr(slot_addr)
);

// File: tb/test_bus_order_guard.sv
`timescale 1ns/1ps
module test_bus_order_guard;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NZ = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, rd_valid = 1'b0, cfg_en_we = 1'b0, bus_ready = 1'b1;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NZ-1:0] cfg_en_val = '0;
    logic [NZ*AW-1:0] zone_base = {16'h7000, 16'h4000};
    logic [NZ*AW-1:0] zone_size = {16'h0100, 16'h1000};
    logic wr_ready, rd_stall, bus_valid, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    bus_order_guard #(.AW(AW), .DW(DW), .NZ(NZ)) i_bus_order_guard (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_stall(rd_stall),
        .cfg_en_we(cfg_en_we), .cfg_en_val(cfg_en_val),
        .zone_base(zone_base), .zone_size(zone_size),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready)
    );

    always #4 clk = ~clk;

    int errors = 0, checks = 0;
    bit done = 0;
    string cur_req = "R1";

    // stimulus queues and bus log
    int rq[$];
    int waq[$];
    int wdq[$];
    int bus_log[$];
    int stall_cnt = 0;
    int ready_mode = 0;
    logic [7:0] lfsr = 8'h5a;

    // reference model state
    bit m_bv = 0, m_we = 0;
    int m_ba = 0, m_bd = 0;
    int m_pa[$];
    int m_pd[$];
    bit [NZ-1:0] m_en = '1;
    bit rd_acc = 0, wr_acc = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit prot(int a);
        bit r = 0;
        for (int z = 0; z < NZ; z++) begin
            int b = int'(zone_base[z*AW +: AW]);
            int s = int'(zone_size[z*AW +: AW]);
            if (m_en[z] && a >= b && a < b + s) r = 1;
        end
        return r;
    endfunction

    // drive inputs at negedge, then compare and step the model before posedge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_acc) void'(rq.pop_front());
            if (wr_acc) begin void'(waq.pop_front()); void'(wdq.pop_front()); end
            rd_valid = rq.size() > 0;
            rd_addr  = rq.size() > 0 ? AW'(rq[0]) : '0;
            wr_valid = waq.size() > 0;
            wr_addr  = waq.size() > 0 ? AW'(waq[0]) : '0;
            wr_data  = wdq.size() > 0 ? DW'(wdq[0]) : '0;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            bus_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
            #3;
            begin
                bit free, ord, rd_go, wq_go, wr_ok;
                free = !m_bv || bus_ready;
                ord = 0;
                if (rd_valid) begin
                    foreach (m_pa[i])
                        if (prot(m_pa[i]) || prot(int'(rd_addr)) || m_pa[i] == int'(rd_addr)) ord = 1;
                    if (wr_valid && (prot(int'(wr_addr)) || prot(int'(rd_addr)) || wr_addr == rd_addr)) ord = 1;
                end
                rd_go = free && rd_valid && !ord;
                wq_go = free && m_pa.size() > 0 && !rd_go;
                wr_ok = m_pa.size() == 0 || wq_go;
                checks++;
                if (bus_valid !== m_bv || rd_stall !== (rd_valid && !rd_go) || wr_ready !== wr_ok ||
                    (m_bv && (bus_we !== m_we || int'(bus_addr) != m_ba || (m_we && int'(bus_wdata) != m_bd)))) begin
                    errors++;
                    $display("FAIL %s cycle compare actual v=%0b we=%0b a=%0h d=%0h st=%0b wr=%0b expected v=%0b we=%0b a=%0h d=%0h st=%0b wr=%0b",
                             cur_req, bus_valid, bus_we, bus_addr, bus_wdata, rd_stall, wr_ready,
                             m_bv, m_we, m_ba, m_bd, rd_valid && !rd_go, wr_ok);
                end
                if (bus_valid && bus_ready) bus_log.push_back({15'd0, bus_we, bus_addr});
                if (rd_stall) stall_cnt++;
                if (rd_go) begin
                    m_bv = 1; m_we = 0; m_ba = int'(rd_addr); m_bd = 0;
                end else if (wq_go) begin
                    m_bv = 1; m_we = 1; m_ba = m_pa.pop_front(); m_bd = m_pd.pop_front();
                end else if (bus_ready) m_bv = 0;
                if (wr_valid && wr_ok) begin m_pa.push_back(int'(wr_addr)); m_pd.push_back(int'(wr_data)); end
                if (cfg_en_we) m_en = cfg_en_val;
                rd_acc = rd_go;
                wr_acc = wr_valid && wr_ok;
            end
        end
    end

    task automatic set_en(bit [NZ-1:0] v);
        @(posedge clk); #1 cfg_en_we = 1; cfg_en_val = v;
        @(posedge clk); #1 cfg_en_we = 0;
    endtask

    // one older write and one younger read presented in the same cycle
    task automatic pair(int wa, int ra, bit wfirst, int exp_stall, string req);
        @(posedge clk);
        cur_req = req; bus_log.delete(); stall_cnt = 0;
        waq.push_back(wa); wdq.push_back(wa ^ 16'h00ff); rq.push_back(ra);
        repeat (8) @(posedge clk);
        check(bus_log.size() == 2, req, "bus count", bus_log.size(), 2);
        if (bus_log.size() > 0)
            check(bus_log[0][16] == wfirst, req, "first is write", int'(bus_log[0][16]), int'(wfirst));
        check(stall_cnt == exp_stall, req, "stall cycles", stall_cnt, exp_stall);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check(bus_valid == 0, "R1", "bus_valid in reset", bus_valid, 0);
        check(wr_ready == 1, "R1", "wr_ready in reset", wr_ready, 1);
        @(posedge clk); #1 rst_n = 1;
        repeat (2) @(posedge clk);
        // R1: zones protected with no configuration
        pair(16'h4010, 16'h4020, 1, 2, "R1");
        // R2: unprotected reordering
        pair(16'h0100, 16'h0200, 0, 0, "R2");
        // R3: either side protected
        pair(16'h4100, 16'h0200, 1, 2, "R3");
        pair(16'h0100, 16'h7010, 1, 2, "R3");
        // R7: zone edges, write outside every zone
        pair(16'h1000, 16'h3fff, 0, 0, "R7");
        pair(16'h1000, 16'h4000, 1, 2, "R7");
        pair(16'h1000, 16'h4fff, 1, 2, "R7");
        pair(16'h1000, 16'h5000, 0, 0, "R7");
        pair(16'h1000, 16'h70ff, 1, 2, "R7");
        pair(16'h1000, 16'h7100, 0, 0, "R7");
        // R6: zone 0 disabled, zone 1 still active
        set_en(2'b10);
        pair(16'h4010, 16'h4020, 0, 0, "R6");
        pair(16'h7010, 16'h4020, 1, 2, "R6");
        // R7: zone of size zero covers nothing
        @(posedge clk); #1 zone_size[AW +: AW] = '0;
        pair(16'h7010, 16'h4020, 0, 0, "R7");
        @(posedge clk); #1 zone_size[AW +: AW] = 16'h0100;
        // R5: same address with every zone disabled
        set_en(2'b00);
        pair(16'h0300, 16'h0300, 1, 2, "R5");
        pair(16'h4010, 16'h4020, 0, 0, "R6");
        set_en(2'b11);
        pair(16'h4010, 16'h4020, 1, 2, "R6");
        // R9: write burst, then back-pressure with bus not ready
        @(posedge clk);
        cur_req = "R9"; bus_log.delete();
        for (int i = 0; i < 4; i++) begin waq.push_back(16'h0400 + i); wdq.push_back(i + 1); end
        ready_mode = 2;
        repeat (10) @(posedge clk);
        ready_mode = 0;
        repeat (10) @(posedge clk);
        check(bus_log.size() == 4, "R9", "write count", bus_log.size(), 4);
        for (int i = 0; i < 4 && i < bus_log.size(); i++)
            check(bus_log[i] == ((1 << 16) | (16'h0400 + i)), "R9", "write order", bus_log[i], (1 << 16) | (16'h0400 + i));
        // R8: random traffic against a stalling bus
        @(posedge clk);
        cur_req = "R8"; bus_log.delete(); ready_mode = 1;
        for (int i = 0; i < 60; i++) begin
            int sel = $urandom_range(0, 5);
            int a = (sel == 0) ? 16'h4000 + $urandom_range(0, 15) :
                    (sel == 1) ? 16'h7000 + $urandom_range(0, 15) : $urandom_range(0, 15);
            if ($urandom_range(0, 1) == 1) begin waq.push_back(a); wdq.push_back($urandom_range(0, 65535)); end
            else rq.push_back(a);
            if (i % 8 == 7) set_en(NZ'($urandom_range(0, 3)));
            @(posedge clk);
        end
        repeat (300) @(posedge clk);
        ready_mode = 0;
        repeat (5) @(posedge clk);
        check(rq.size() == 0 && waq.size() == 0, "R8", "stimulus drained", rq.size() + waq.size(), 0);
        check(bus_valid == 0, "R8", "bus idle at end", bus_valid, 0);
        finish_run();
    end
endmodule